// File: doc/BRIEF.md
# Peak Input Indicator with Timed Refresh

This block watches a stream of decimated, signed two's-complement audio samples and keeps two running extremes: the largest and the smallest sample seen since tracking last restarted. Both extremes are presented as registered output words. A downstream level monitor can use them, for example to keep a loudspeaker out of overload.

A free-running refresh timer runs on the fast clock and expires once every `REFRESH_LAST + 1` cycles. With the default 24-bit terminal value and a 5.12 MHz clock, that is about 3.28 s. Expiry arms a restart. The first valid sample in the expiry cycle or after it loads both extremes with its own value, so the old extremes are dropped. A single-cycle refresh pulse marks that reload. The timer keeps running whether samples arrive or not.

Top module: `peak_input_indicator`

## Requirements
- R1: While reset is high, and on the first cycle after it, the high output holds the most negative code (sign bit 1, all other bits 0), the low output holds the most positive code (sign bit 0, all other bits 1), and the refresh pulse is 0.
- R2: A valid sample that is greater than the held high value under signed two's-complement comparison replaces the high value. The new value shows on the output one clock after the sample is presented.
- R3: A valid sample that is less than the held low value under signed comparison replaces the low value. The new value shows on the output one clock after the sample is presented.
- R4: A sample whose valid strobe is low has no effect on either held value, whatever its data bits are.
- R5: The refresh timer expires on the clock edge that ends cycle `REFRESH_LAST` after reset is released, and then once every `REFRESH_LAST + 1` cycles after that. Sample traffic does not affect it.
- R6: The first valid sample in an expiry cycle, or in any later cycle before the next reload, loads both held values with that sample. This reload replaces any update under R2 or R3. If the sample coincides with expiry, that same sample is used.
- R7: `refresh_o` is high for exactly one cycle: the cycle in which the outputs first show the reloaded value. It is low at all other times.
- R8: Once any valid sample has been accepted since reset, the high output is never less than the low output under signed comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_i | input | DATA_W | Decimated sample, signed two's complement |
| smp_vld_i | input | 1 | Marks `smp_i` as a valid sample this cycle |
| pk_hi_o | output | DATA_W | Largest sample since the last reload |
| pk_lo_o | output | DATA_W | Smallest sample since the last reload |
| refresh_o | output | 1 | One-cycle pulse marking a tracking restart |

## Verification
The bench uses a 6-bit sample width and a 100-cycle refresh period. It sweeps every code upward and downward across the sign boundary, so a design that compares unsigned values would take -1 as the maximum and be caught. The bench holds the valid strobe low through several expiries while the data bits wiggle. A design that reloads from invalid data, or that drops an armed refresh, shows wrong values there or no pulse. The bench also lines a valid sample up exactly with the expiry cycle. A design that gives the compare path priority over the reload there keeps the stale extreme.

// File: rtl/peak_pkg.sv
package peak_pkg;
  typedef enum logic {
    TRACK_MAX = 1'b0,
    TRACK_MIN = 1'b1
  } track_kind_e;
endpackage

// File: rtl/peak_refresh_timer.sv
module peak_refresh_timer #(
  parameter int unsigned        CNT_W        = 24,
  parameter logic [CNT_W-1:0]   REFRESH_LAST = '1
) (
  input  logic clk,
  input  logic rst,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = (cnt_q == REFRESH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (expire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= REFRESH_LAST);  // R5
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_q == '0));  // R5
endmodule

// File: rtl/peak_extreme_reg.sv
module peak_extreme_reg
  import peak_pkg::*;
#(
  parameter int unsigned  DATA_W = 16,
  parameter track_kind_e  KIND   = TRACK_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic              better;
  logic [DATA_W-1:0] rst_val;

  generate
    if (KIND == TRACK_MAX) begin : g_max
      assign better  = $signed(smp_i) > $signed(q_o);
      assign rst_val = MOST_NEG;
      AST_MAX_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $signed(q_o) >= $signed($past(q_o)));  // R2
    end else begin : g_min
      assign better  = $signed(smp_i) < $signed(q_o);
      assign rst_val = MOST_POS;
      AST_MIN_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $signed(q_o) <= $signed($past(q_o)));  // R3
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= rst_val;
    end else if (load_i) begin
      q_o <= smp_i;
    end else if (vld_i && better) begin
      q_o <= smp_i;
    end
  end

  AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(q_o));  // R4
endmodule

// File: rtl/peak_input_indicator.sv
module peak_input_indicator
  import peak_pkg::*;
#(
  parameter int unsigned      DATA_W       = 16,
  parameter int unsigned      CNT_W        = 24,
  parameter logic [CNT_W-1:0] REFRESH_LAST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              smp_vld_i,
  output logic [DATA_W-1:0] pk_hi_o,
  output logic [DATA_W-1:0] pk_lo_o,
  output logic              refresh_o
);
  logic expire;
  logic armed_q;
  logic do_load;

  peak_refresh_timer #(
    .CNT_W        (CNT_W),
    .REFRESH_LAST (REFRESH_LAST)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .expire_o (expire)
  );

  assign do_load = (expire | armed_q) & smp_vld_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      refresh_o <= 1'b0;
    end else begin
      refresh_o <= do_load;
      if (do_load) begin
        armed_q <= 1'b0;
      end else if (expire) begin
        armed_q <= 1'b1;
      end
    end
  end

  peak_extreme_reg #(.DATA_W(DATA_W), .KIND(TRACK_MAX)) u_hi (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (smp_vld_i),
    .load_i (do_load),
    .smp_i  (smp_i),
    .q_o    (pk_hi_o)
  );

  peak_extreme_reg #(.DATA_W(DATA_W), .KIND(TRACK_MIN)) u_lo (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (smp_vld_i),
    .load_i (do_load),
    .smp_i  (smp_i),
    .q_o    (pk_lo_o)
  );

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst)            seen_q <= 1'b0;
    else if (smp_vld_i) seen_q <= 1'b1;
  end

  AST_ORDER: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> $signed(pk_hi_o) >= $signed(pk_lo_o));  // R8
  AST_RELOAD_EQUAL: assert property (@(posedge clk) disable iff (rst)
    refresh_o |-> (pk_hi_o == pk_lo_o));  // R6
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (pk_hi_o == $past(smp_i)) && refresh_o);  // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    (refresh_o && REFRESH_LAST != '0) |=> !refresh_o);  // R7
endmodule

// File: tb/peak_input_indicator_tb.sv
module peak_input_indicator_tb;
  localparam int DW   = 6;
  localparam int CW   = 8;
  localparam int LAST = 99;
  localparam int VMIN = -(1 << (DW-1));
  localparam int VMAX = (1 << (DW-1)) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] smp = '0;
  logic          smp_vld = 1'b0;
  logic [DW-1:0] pk_hi, pk_lo;
  logic          refresh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mcnt = 0;
  bit marmed = 1'b0;
  bit mseen = 1'b0;
  int exp_hi = VMIN;
  int exp_lo = VMAX;
  bit exp_ref = 1'b0;
  int pulses = 0;
  int lfsr = 32'h1ACE;

  always #5 clk = ~clk;

  peak_input_indicator #(
    .DATA_W       (DW),
    .CNT_W        (CW),
    .REFRESH_LAST (CW'(LAST))
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .smp_i     (smp),
    .smp_vld_i (smp_vld),
    .pk_hi_o   (pk_hi),
    .pk_lo_o   (pk_lo),
    .refresh_o (refresh)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    int hi_s, lo_s;
    hi_s = $signed(pk_hi);
    lo_s = $signed(pk_lo);
    chk("R2", "peak high", hi_s, exp_hi);
    chk("R3", "peak low", lo_s, exp_lo);
    chk("R7", "refresh pulse", int'(refresh), int'(exp_ref));
    if (mseen) chk("R8", "high>=low", int'(hi_s >= lo_s), 1);
  endtask

  // called at a negative edge; leaves at the next negative edge
  task automatic step(input bit v, input int val);
    bit expire, load;
    smp_vld = v;
    smp     = val[DW-1:0];
    @(posedge clk);
    expire = (mcnt == LAST);
    load   = (expire || marmed) && v;
    exp_ref = load;
    if (load) begin
      exp_hi = val; exp_lo = val; marmed = 1'b0; pulses++;
    end else begin
      if (expire) marmed = 1'b1;
      if (v) begin
        if (val > exp_hi) exp_hi = val;
        if (val < exp_lo) exp_lo = val;
      end
    end
    if (v) mseen = 1'b1;
    mcnt = expire ? 0 : mcnt + 1;
    @(negedge clk);
    cmp_all();
  endtask

  function automatic int next_val();
    lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
    return (lfsr % (VMAX - VMIN + 1)) + VMIN;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1", "reset high", $signed(pk_hi), VMIN);
    chk("R1", "reset low", $signed(pk_lo), VMAX);
    chk("R1", "reset pulse", int'(refresh), 0);
    rst = 1'b0;
    // R4: invalid data before any valid sample leaves the reset values
    for (int i = 0; i < 5; i++) step(1'b0, VMAX - i);
    chk("R4", "idle high", $signed(pk_hi), VMIN);
    chk("R4", "idle low", $signed(pk_lo), VMAX);

    // R2 R3: exhaustive sweeps across the sign boundary
    for (int v = VMIN; v <= VMAX; v++) step(1'b1, v);
    for (int v = VMAX; v >= VMIN; v--) step(1'b1, v);

    // R5: continuous valid, one reload per period
    p0 = pulses;
    for (int i = 0; i < 10 * (LAST + 1); i++) step(1'b1, next_val());
    chk("R5", "pulses per 10 periods", pulses - p0, 10);

    // mixed valid / invalid traffic
    for (int i = 0; i < 800; i++) step((next_val() & 3) != 0, next_val());

    // R4 R6: long idle across expiries, then one sample reloads both
    for (int i = 0; i < 2 * (LAST + 1) + 7; i++) step(1'b0, next_val());
    step(1'b1, -3);
    chk("R6", "armed reload high", $signed(pk_hi), -3);
    chk("R6", "armed reload low", $signed(pk_lo), -3);
    chk("R7", "armed reload pulse", int'(refresh), 1);
    step(1'b1, 5);
    chk("R7", "pulse width", int'(refresh), 0);

    // R6: sample coincident with expiry, after a wider range was held
    step(1'b1, VMAX);
    step(1'b1, VMIN);
    while (mcnt != LAST) step(1'b0, 0);
    step(1'b1, 7);
    chk("R6", "coincident reload high", $signed(pk_hi), 7);
    chk("R6", "coincident reload low", $signed(pk_lo), 7);
    step(1'b1, -1);
    chk("R3", "after reload low", $signed(pk_lo), -1);
    chk("R2", "after reload high", $signed(pk_hi), 7);

    // R1: reset mid-stream restores the reset values
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "re-reset high", $signed(pk_hi), VMIN);
    chk("R1", "re-reset low", $signed(pk_lo), VMAX);
    chk("R1", "re-reset pulse", int'(refresh), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule